// File: doc/BRIEF.md
# Counter Snapshot Capture Unit

This block sits beside one 24-bit position counter and freezes its value into a read buffer on a chosen event. The trigger can be a software read, a rising edge of the index line, a rising edge of either of two shared digital inputs, or a rising edge of a periodic timer pulse. A 3-bit select field picks the trigger for each channel on its own. Software reads the buffer as three byte registers through a simple combinational byte read port. The counter itself lives outside this block.

In software mode a capture happens only when the most significant byte is read. That read returns the live high byte in the same cycle and loads all three bytes at the closing clock edge. The two lower bytes are then read from the same snapshot. When the clear-on-capture bit is set, the block raises a one-cycle clear request in the cycle whose closing edge performs the capture, so the external counter can return to its reset value on that same edge.

Each hardware trigger line first passes through a synchronizer. It then feeds a small edge state machine with three states. EDG_INIT waits, after reset, until the synchronizer holds real data. It then moves to EDG_LOW or EDG_HIGH according to the sampled level, and never reports an edge on that move. EDG_LOW moves to EDG_HIGH when the level is high, and emits a one-cycle rise strobe while it does so. EDG_HIGH moves back to EDG_LOW when the level is low.

Top module: `snap_latch_unit`

## Requirements
- R1: After reset the buffer holds zero, every byte read returns 0x00, and `cnt_clr_req` is low.
- R2: Byte address 0 returns counter bits 7..0, address 1 returns bits 15..8, and address 2 returns bits 23..16. Address 3 returns 0x00.
- R3: With select 000 (software), a read of address 2 returns the live counter bits 23..16 in that cycle and captures the whole counter at that cycle's closing clock edge. Later reads of addresses 0 and 1 return that snapshot.
- R4: With select 000, reads of addresses 0 and 1 neither capture nor raise `cnt_clr_req`, and edges on the hardware lines are ignored.
- R5: With select 001 (index), a rising index level that is applied just after clock edge E0 raises `cnt_clr_req` (when enabled) in the cycle after E2. The buffer holds the counter value taken at E3.
- R6: Select 010 captures on a rising edge of `di0_in`, 011 on a rising edge of `di1_in`, and 100 on a rising edge of `tmr_in`. Edges on lines that are not selected have no effect.
- R7: A trigger level that stays high gives exactly one capture, and a falling edge gives none.
- R8: Select codes 101, 110 and 111 give no capture from any source, including a read of address 2, and never raise `cnt_clr_req`.
- R9: With `clr_on_cap` = 1, `cnt_clr_req` is a single-cycle pulse in the cycle that ends with a capture. With `clr_on_cap` = 0 it stays low.
- R10: A trigger line that is already high when reset ends, or when its code is selected, does not capture until it falls and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_val | input | 24 | Live counter value |
| idx_in | input | 1 | Filtered index line |
| di0_in | input | 1 | Filtered shared digital input 0 |
| di1_in | input | 1 | Filtered shared digital input 1 |
| tmr_in | input | 1 | Timer pulse |
| src_sel | input | 3 | Trigger select (000 sw, 001 index, 010 di0, 011 di1, 100 timer) |
| clr_on_cap | input | 1 | Request a counter clear on each capture |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 2 | Byte address |
| rd_data | output | 8 | Read data (combinational) |
| cnt_clr_req | output | 1 | One-cycle clear request to the counter |

## Verification
A hardware trigger takes three clock edges to act. Two edges fill the synchronizer, the clear request is visible after the second edge, and the buffer changes at the third edge. The bench therefore samples one nanosecond after each edge, and checks that the clear request is low after the first edge, high after the second and low again after the third. It also checks that the old buffer value is still present until the third edge. Software capture takes effect at the edge that closes the read cycle: the returned byte is sampled before that edge, and the low and middle bytes are sampled in the cycles that follow. For ignored stimuli the bench waits well past the three-edge latency and then reads the buffer through the byte port.

// File: rtl/snap_pkg.sv
package snap_pkg;

    typedef enum logic [2:0] {
        SRC_SWREAD = 3'd0,
        SRC_INDEX  = 3'd1,
        SRC_DI0    = 3'd2,
        SRC_DI1    = 3'd3,
        SRC_TIMER  = 3'd4
    } src_sel_e;

    localparam int HW_SRC_N = 4;
    localparam int HW_INDEX = 0;
    localparam int HW_DI0   = 1;
    localparam int HW_DI1   = 2;
    localparam int HW_TIMER = 3;

    typedef enum logic [1:0] {
        EDG_INIT = 2'd0,
        EDG_LOW  = 2'd1,
        EDG_HIGH = 2'd2
    } edge_state_e;

endpackage

// File: rtl/snap_sync.sv
module snap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                pipe_q[i] <= pipe_q[i-1];
            end
        end
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/snap_edge_fsm.sv
module snap_edge_fsm
    import snap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic armed,
    input  logic lvl,
    output logic rise
);
    edge_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDG_INIT: if (armed) state_d = lvl ? EDG_HIGH : EDG_LOW;
            EDG_LOW:  if (lvl)   state_d = EDG_HIGH;
            EDG_HIGH: if (!lvl)  state_d = EDG_LOW;
            default:             state_d = EDG_INIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EDG_INIT;
        else        state_q <= state_d;
    end

    always_comb begin
        rise = 1'b0;
        unique case (state_q)
            EDG_LOW: rise = lvl;
            default: rise = 1'b0;
        endcase
    end

    // R7
    rise_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R10
    init_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == EDG_INIT) |-> !rise);
endmodule

// File: rtl/snap_trig_sel.sv
module snap_trig_sel
    import snap_pkg::*;
(
    input  logic [2:0]          sel,
    input  logic [HW_SRC_N-1:0] hw_rise,
    input  logic                sw_hi_rd,
    output logic                cap
);
    always_comb begin
        cap = 1'b0;
        unique case (sel)
            SRC_SWREAD: cap = sw_hi_rd;
            SRC_INDEX:  cap = hw_rise[HW_INDEX];
            SRC_DI0:    cap = hw_rise[HW_DI0];
            SRC_DI1:    cap = hw_rise[HW_DI1];
            SRC_TIMER:  cap = hw_rise[HW_TIMER];
            default:    cap = 1'b0;
        endcase
    end
endmodule

// File: rtl/snap_latch_unit.sv
module snap_latch_unit
    import snap_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [CNT_W-1:0]                 cnt_val,
    input  logic                             idx_in,
    input  logic                             di0_in,
    input  logic                             di1_in,
    input  logic                             tmr_in,
    input  logic [2:0]                       src_sel,
    input  logic                             clr_on_cap,
    input  logic                             rd_en,
    input  logic [$clog2(CNT_W/8)-1:0]       rd_addr,
    output logic [7:0]                       rd_data,
    output logic                             cnt_clr_req
);
    localparam int BYTE_N   = CNT_W / 8;
    localparam int ADDR_W   = $clog2(BYTE_N);
    localparam int HI_ADDR  = BYTE_N - 1;
    localparam int SETTLE_W = $clog2(SYNC_STAGES + 1);

    logic [HW_SRC_N-1:0] hw_raw, hw_lvl, hw_rise;
    logic [SETTLE_W-1:0] settle_q;
    logic                settled;
    logic                sw_hi_rd, bypass;
    logic                cap_stb;
    logic [CNT_W-1:0]    snap_q;

    assign hw_raw[HW_INDEX] = idx_in;
    assign hw_raw[HW_DI0]   = di0_in;
    assign hw_raw[HW_DI1]   = di1_in;
    assign hw_raw[HW_TIMER] = tmr_in;

    // settle counter: edge machines stay in EDG_INIT until the synchronizers are full
    always_ff @(posedge clk) begin
        if (!rst_n)       settle_q <= '0;
        else if (!settled) settle_q <= settle_q + 1'b1;
    end
    assign settled = (settle_q == SETTLE_W'(SYNC_STAGES));

    for (genvar g = 0; g < HW_SRC_N; g++) begin : g_hw
        snap_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (hw_raw[g]),
            .q    (hw_lvl[g])
        );
        snap_edge_fsm u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .armed(settled),
            .lvl  (hw_lvl[g]),
            .rise (hw_rise[g])
        );
    end

    assign sw_hi_rd = rd_en && (rd_addr == ADDR_W'(HI_ADDR));
    assign bypass   = sw_hi_rd && (src_sel == SRC_SWREAD);

    snap_trig_sel u_trig (
        .sel     (src_sel),
        .hw_rise (hw_rise),
        .sw_hi_rd(sw_hi_rd),
        .cap     (cap_stb)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)       snap_q <= '0;
        else if (cap_stb) snap_q <= cnt_val;
    end

    assign cnt_clr_req = cap_stb && clr_on_cap;

    always_comb begin
        rd_data = 8'h00;
        if (rd_en) begin
            if (bypass) begin
                rd_data = cnt_val[HI_ADDR*8 +: 8];
            end else begin
                for (int b = 0; b < BYTE_N; b++) begin
                    if (rd_addr == ADDR_W'(b)) rd_data = snap_q[b*8 +: 8];
                end
            end
        end
    end

    // R3
    cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_stb |=> (snap_q == $past(cnt_val)));

    // R4
    low_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == SRC_SWREAD && !sw_hi_rd) |=> $stable(snap_q));

    // R8
    unused_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel > 3'd4) |=> $stable(snap_q));

    // R9
    clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr_req && src_sel != SRC_SWREAD) |=> !cnt_clr_req);
endmodule

// File: tb/test_snap_latch_unit.sv
module test_snap_latch_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] cnt_val = '0;
    logic        idx_in = 0, di0_in = 0, di1_in = 0, tmr_in = 0;
    logic [2:0]  src_sel = 3'd0;
    logic        clr_on_cap = 0;
    logic        rd_en = 0;
    logic [1:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        cnt_clr_req;

    int n_chk = 0;
    int n_err = 0;
    bit clr_seen = 0;
    logic [23:0] exp_buf = '0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(negedge clk) if (cnt_clr_req) clr_seen = 1;

    snap_latch_unit i_snap_latch_unit (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val),
        .idx_in(idx_in), .di0_in(di0_in), .di1_in(di1_in), .tmr_in(tmr_in),
        .src_sel(src_sel), .clr_on_cap(clr_on_cap),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .cnt_clr_req(cnt_clr_req)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] d);
        rd_en = 1; rd_addr = a; #1; d = rd_data; rd_en = 0; #1;
    endtask

    task automatic peek_low2(output logic [15:0] v);
        logic [7:0] b0, b1;
        peek(2'd0, b0); peek(2'd1, b1);
        v = {b1, b0};
    endtask

    task automatic rd_clk(input logic [1:0] a, output logic [7:0] d, output logic c);
        rd_en = 1; rd_addr = a; #1; d = rd_data; c = cnt_clr_req;
        @(posedge clk); #1; rd_en = 0;
    endtask

    task automatic set_line(input int w, input logic v);
        case (w)
            0: idx_in = v;
            1: di0_in = v;
            2: di1_in = v;
            default: tmr_in = v;
        endcase
    endtask

    task automatic pulse_line(input int w);
        set_line(w, 1); step(4); set_line(w, 0); step(4);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        idx_in = 1; src_sel = 3'd1; cnt_val = 24'hABCDEF;
        step(3); rst_n = 1;
        for (int a = 0; a < 4; a++) begin
            peek(2'(a), d); chk(d == 8'h00, "R1 reset byte", d, 0);
        end
        chk(cnt_clr_req == 0, "R1 clr low", cnt_clr_req, 0);
        step(6);
        peek(2'd0, d); chk(d == 8'h00, "R10 high at reset no capture", d, 0);
        idx_in = 0; step(4);
        peek(2'd0, d); chk(d == 8'h00, "R10 fall no capture", d, 0);
    endtask

    task automatic t_byte_map();
        logic [7:0] d;
        src_sel = 3'd1; clr_on_cap = 0; cnt_val = 24'h123456;
        pulse_line(0); exp_buf = 24'h123456;
        peek(2'd0, d); chk(d == 8'h56, "R2 byte0", d, 8'h56);
        peek(2'd1, d); chk(d == 8'h34, "R2 byte1", d, 8'h34);
        peek(2'd2, d); chk(d == 8'h12, "R2 byte2", d, 8'h12);
        peek(2'd3, d); chk(d == 8'h00, "R2 addr3", d, 0);
    endtask

    task automatic t_hw_timing();
        logic [7:0] d;
        src_sel = 3'd1; clr_on_cap = 1; cnt_val = 24'h0A0B0C;
        idx_in = 1;
        step(1);
        chk(cnt_clr_req == 0, "R5 clr after E1", cnt_clr_req, 0);
        step(1);
        chk(cnt_clr_req == 1, "R9 clr after E2", cnt_clr_req, 1);
        peek(2'd0, d); chk(d == 8'h56, "R5 old buffer before E3", d, 8'h56);
        step(1);
        chk(cnt_clr_req == 0, "R9 clr one cycle", cnt_clr_req, 0);
        peek(2'd0, d); chk(d == 8'h0C, "R5 captured at E3", d, 8'h0C);
        exp_buf = 24'h0A0B0C;
        clr_seen = 0; cnt_val = 24'h111111; step(6);
        peek(2'd1, d); chk(d == 8'h0B, "R7 level held one capture", d, 8'h0B);
        chk(clr_seen == 0, "R7 no extra clr", clr_seen, 0);
        idx_in = 0; step(5);
        peek(2'd2, d); chk(d == 8'h0A, "R7 falling edge no capture", d, 8'h0A);
    endtask

    task automatic t_hw_src(input logic [2:0] sel, input int w, input logic [23:0] v);
        logic [7:0] d;
        src_sel = sel; clr_on_cap = 0; cnt_val = v;
        for (int o = 0; o < 4; o++) if (o != w) pulse_line(o);
        peek(2'd0, d); chk(d == exp_buf[7:0], "R6 unselected lines ignored", d, exp_buf[7:0]);
        pulse_line(w); exp_buf = v;
        peek(2'd0, d); chk(d == v[7:0], "R6 selected source byte0", d, v[7:0]);
        peek(2'd2, d); chk(d == v[23:16], "R6 selected source byte2", d, v[23:16]);
    endtask

    task automatic t_sw();
        logic [7:0] d; logic c; logic [15:0] lo;
        src_sel = 3'd0; clr_on_cap = 1; cnt_val = 24'h89ABCD;
        rd_clk(2'd2, d, c);
        chk(d == 8'h89, "R3 live high byte", d, 8'h89);
        chk(c == 1, "R9 sw clr", c, 1);
        exp_buf = 24'h89ABCD; cnt_val = 24'h000000;
        rd_clk(2'd1, d, c);
        chk(d == 8'hAB, "R3 mid from snapshot", d, 8'hAB);
        chk(c == 0, "R4 mid read no clr", c, 0);
        rd_clk(2'd0, d, c);
        chk(d == 8'hCD, "R3 low from snapshot", d, 8'hCD);
        cnt_val = 24'h777777;
        rd_clk(2'd0, d, c); rd_clk(2'd1, d, c);
        peek_low2(lo); chk(lo == 16'hABCD, "R4 low reads no capture", lo, 16'hABCD);
        for (int w = 0; w < 4; w++) pulse_line(w);
        peek_low2(lo); chk(lo == 16'hABCD, "R4 hw edges ignored in sw", lo, 16'hABCD);
    endtask

    task automatic t_unused();
        logic [7:0] d; logic c;
        for (int s = 5; s < 8; s++) begin
            src_sel = 3'(s); clr_on_cap = 1; cnt_val = 24'h5A5A5A; clr_seen = 0;
            rd_clk(2'd2, d, c);
            chk(d == exp_buf[23:16], "R8 high read from buffer", d, exp_buf[23:16]);
            for (int w = 0; w < 4; w++) pulse_line(w);
            peek(2'd0, d); chk(d == exp_buf[7:0], "R8 no capture", d, exp_buf[7:0]);
            chk(clr_seen == 0, "R8 no clr", clr_seen, 0);
        end
    endtask

    task automatic t_already_high();
        logic [7:0] d;
        src_sel = 3'd0; di1_in = 1; step(5);
        src_sel = 3'd3; cnt_val = 24'h3C3C3C; step(5);
        peek(2'd0, d); chk(d == exp_buf[7:0], "R10 high when selected", d, exp_buf[7:0]);
        di1_in = 0; step(4); pulse_line(2); exp_buf = 24'h3C3C3C;
        peek(2'd0, d); chk(d == 8'h3C, "R10 capture after new rise", d, 8'h3C);
    endtask

    task automatic t_lc_off();
        logic [7:0] d;
        src_sel = 3'd4; clr_on_cap = 0; cnt_val = 24'hC0FFEE; clr_seen = 0;
        pulse_line(3); exp_buf = 24'hC0FFEE;
        chk(clr_seen == 0, "R9 no clr when disabled", clr_seen, 0);
        peek(2'd1, d); chk(d == 8'hFF, "R6 timer capture", d, 8'hFF);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_byte_map();
        t_hw_timing();
        t_hw_src(3'd2, 1, 24'h2468AC);
        t_hw_src(3'd3, 2, 24'h13579B);
        t_hw_src(3'd4, 3, 24'hFEDCBA);
        t_sw();
        t_unused();
        t_already_high();
        t_lc_off();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule